// File: doc/BRIEF.md
# Power Management Control and Status Register

This block is the 32-bit power management control and status word of a PCI-style function. It sits behind a plain configuration read/write port with byte enables and answers at byte address 54h. The word holds the function's power state, which can be D0 (fully on) or D3hot (quiescent), and a wake enable bit. It also holds a wake status flag that latches every PME event, whether or not wake is enabled.

From these bits the block drives the current power state and a decode gate for I/O and memory space. It also drives an interrupt mask and a wake request to the system event logic. When software moves the function from D3hot back to D0, the block emits a one-cycle internal soft reset. The wake status and wake enable bits sit in an always-on domain: only the power-on reset clears them. The function reset and the soft reset return the power state to D0 and leave the wake bits alone.

Top module: `pm_ctrl_reg`

## Requirements
- R1: After power-on reset, a read of the register returns 00000000h, `pwr_state` is 00 (D0), `decode_en` is 1, and `irq_mask`, `wake_req` and `soft_rst` are 0.
- R2: Every bit other than 15, 8, 1 and 0 reads as 0, and writing ones to those bits changes nothing.
- R3: Bit 15 (wake status) is set by a `pme_event` pulse whether or not bit 8 is set. Writing 1 to bit 15 clears it, and writing 0 to it leaves it unchanged.
- R4: Bit 8 (wake enable) is read/write. `wake_req` is 1 exactly when bits 15 and 8 are both 1.
- R5: When a `pme_event` coincides with a write of 1 to bit 15, the bit stays set.
- R6: The function reset `fn_rst` does not change bits 15 and 8. Only `por_rst` clears them.
- R7: Bits 1:0 hold the power state, with 00 meaning D0 and 11 meaning D3hot. A write of 01 or 10 completes normally but leaves the state unchanged.
- R8: In D3hot, `decode_en` is 0 and `irq_mask` is 1, and register reads and writes still work.
- R9: A write of 00 to bits 1:0 while in D3hot raises `soft_rst` for exactly one cycle, registered in the clock after the write. Writes that leave D0 in place, or that enter D3hot, give no pulse.
- R10: The soft reset and `fn_rst` force the power state to D0 and leave bits 15 and 8 untouched. A state write accepted while `soft_rst` is high is overridden by D0.
- R11: A write updates only the bytes whose byte enables are 1. `acc_be[0]` covers bits 1:0, and `acc_be[1]` covers bits 15 and 8.
- R12: Read data appears on `acc_rdata` in the cycle after the read strobe and is 0 in other cycles. Accesses to any word other than 54h leave the register unchanged and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous active high; clears everything |
| fn_rst | input | 1 | Function reset, synchronous active high; spares the wake bits |
| acc_addr | input | 8 | Configuration byte address |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_be | input | 4 | Byte enables for the write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, one cycle after the read strobe |
| pme_event | input | 1 | Wake event from the function |
| pwr_state | output | 2 | Current power state (00 D0, 11 D3hot) |
| decode_en | output | 1 | I/O and memory decode allowed |
| irq_mask | output | 1 | Interrupts blocked |
| wake_req | output | 1 | Request to set the shared system wake status |
| soft_rst | output | 1 | One-cycle internal soft reset pulse |

## Verification
A corrupted power state shows on `pwr_state`, `decode_en` and `irq_mask` at the first sample after the offending edge. A missing or duplicated soft reset pulse shows on `soft_rst` within one cycle of the write that leaves D3hot. Wrong wake status or wake enable bits show on `wake_req` at once. Because the function reset must spare those bits, they are also read back after each kind of reset. An error in the byte lanes or the address match appears only when the word is next read, one cycle after that read's strobe.

// File: rtl/pmcsr_pkg.sv
package pmcsr_pkg;

    typedef enum logic [1:0] {
        PS_D0     = 2'b00,
        PS_RSV1   = 2'b01,
        PS_RSV2   = 2'b10,
        PS_D3HOT  = 2'b11
    } pstate_e;

    // Bit positions inside the 32-bit word (software-visible layout)
    localparam int unsigned WAKE_ST_BIT = 15;
    localparam int unsigned WAKE_EN_BIT = 8;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned LANES       = DATA_W / 8;

    // Decoded write request, one field per writable item
    typedef struct packed {
        logic       ps_we;    // byte lane 0 written
        logic [1:0] ps_code;  // requested state code
        logic       wake_we;  // byte lane 1 written
        logic       en_val;   // new wake enable
        logic       st_clr;   // one written to wake status
    } wr_req_t;

    function automatic logic ps_code_ok(input logic [1:0] code);
        return (code == PS_D0) || (code == PS_D3HOT);
    endfunction

    function automatic logic [DATA_W-1:0] pack_word(input pstate_e ps,
                                                    input logic en,
                                                    input logic st);
        logic [DATA_W-1:0] w;
        w              = '0;
        w[1:0]         = ps;
        w[WAKE_EN_BIT] = en;
        w[WAKE_ST_BIT] = st;
        return w;
    endfunction

endpackage

// File: rtl/pm_access_dec.sv
module pm_access_dec
    import pmcsr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h54
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [LANES-1:0]  acc_be,
    input  logic [DATA_W-1:0] acc_wdata,
    output wr_req_t           wr_req,
    output logic              rd_hit
);
    localparam int unsigned WORD_LSB = 2;

    logic             word_hit;
    logic [LANES-1:0] lane_we;

    assign word_hit = (acc_addr[ADDR_W-1:WORD_LSB] == REG_OFS[ADDR_W-1:WORD_LSB]);
    assign rd_hit   = acc_rd && word_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = acc_wr && word_hit && acc_be[g];
    end

    always_comb begin
        wr_req         = '0;
        wr_req.ps_we   = lane_we[0];
        wr_req.ps_code = acc_wdata[1:0];
        wr_req.wake_we = lane_we[1];
        wr_req.en_val  = acc_wdata[WAKE_EN_BIT];
        wr_req.st_clr  = acc_wdata[WAKE_ST_BIT];
    end

    // Bits carrying no writable state in this word
    logic unused_bits;
    assign unused_bits = ^{acc_addr[WORD_LSB-1:0], lane_we[LANES-1:2],
                           acc_wdata[DATA_W-1:16], acc_wdata[14:9], acc_wdata[7:2]};

endmodule

// File: rtl/pm_state_ctl.sv
module pm_state_ctl
    import pmcsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr_req,
    output pstate_e ps_q,
    output logic    soft_q
);
    logic leave_d3;

    assign leave_d3 = wr_req.ps_we && (ps_q == PS_D3HOT) && (wr_req.ps_code == PS_D0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q   <= PS_D0;
            soft_q <= 1'b0;
        end else begin
            soft_q <= leave_d3;
            if (soft_q) begin
                ps_q <= PS_D0;
            end else if (wr_req.ps_we && ps_code_ok(wr_req.ps_code)) begin
                ps_q <= pstate_e'(wr_req.ps_code);
            end
        end
    end

    assert_bad_code_dropped_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_req.ps_we && !ps_code_ok(wr_req.ps_code)) |=> $stable(ps_q));

    assert_pulse_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        soft_q |=> !soft_q);

    assert_pulse_lands_d0_R10: assert property (@(posedge clk) disable iff (rst)
        soft_q |=> (ps_q == PS_D0));

endmodule

// File: rtl/pm_wake_bits.sv
module pm_wake_bits
    import pmcsr_pkg::*;
(
    input  logic    clk,
    input  logic    por_rst,
    input  wr_req_t wr_req,
    input  logic    pme_event,
    output logic    st_q,
    output logic    en_q
);
    logic clr_req;

    assign clr_req = wr_req.wake_we && wr_req.st_clr;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            st_q <= 1'b0;
            en_q <= 1'b0;
        end else begin
            if (wr_req.wake_we) begin
                en_q <= wr_req.en_val;
            end
            if (pme_event) begin
                st_q <= 1'b1;
            end else if (clr_req) begin
                st_q <= 1'b0;
            end
        end
    end

    assert_event_sets_status_R3: assert property (@(posedge clk) disable iff (por_rst)
        pme_event |=> st_q);

    assert_zero_write_keeps_R3: assert property (@(posedge clk) disable iff (por_rst)
        (st_q && !clr_req) |=> st_q);

    assert_event_beats_clear_R5: assert property (@(posedge clk) disable iff (por_rst)
        (pme_event && clr_req) |=> st_q);

endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
    import pmcsr_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h54
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              fn_rst,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [3:0]        acc_be,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic              pme_event,
    output logic [1:0]        pwr_state,
    output logic              decode_en,
    output logic              irq_mask,
    output logic              wake_req,
    output logic              soft_rst
);
    localparam logic [31:0] LIVE_MASK = (32'h1 << WAKE_ST_BIT) | (32'h1 << WAKE_EN_BIT) | 32'h3;

    wr_req_t wr_req;
    logic    rd_hit;
    logic    fn_domain_rst;
    pstate_e ps_q;
    logic    wake_st;
    logic    wake_en;

    assign fn_domain_rst = por_rst || fn_rst;

    pm_access_dec #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_dec (
        .acc_addr  (acc_addr),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd),
        .acc_be    (acc_be),
        .acc_wdata (acc_wdata),
        .wr_req    (wr_req),
        .rd_hit    (rd_hit)
    );

    pm_state_ctl u_state (
        .clk    (clk),
        .rst    (fn_domain_rst),
        .wr_req (wr_req),
        .ps_q   (ps_q),
        .soft_q (soft_rst)
    );

    pm_wake_bits u_wake (
        .clk       (clk),
        .por_rst   (por_rst),
        .wr_req    (wr_req),
        .pme_event (pme_event),
        .st_q      (wake_st),
        .en_q      (wake_en)
    );

    always_ff @(posedge clk) begin
        if (fn_domain_rst) begin
            acc_rdata <= '0;
        end else begin
            acc_rdata <= rd_hit ? pack_word(ps_q, wake_en, wake_st) : '0;
        end
    end

    assign pwr_state = ps_q;
    assign decode_en = (ps_q == PS_D0);
    assign irq_mask  = (ps_q == PS_D3HOT);
    assign wake_req  = wake_st && wake_en;

    assert_fn_spares_wake_R6: assert property (@(posedge clk) disable iff (por_rst)
        (fn_rst && !wr_req.wake_we && !pme_event) |=> ($stable(wake_st) && $stable(wake_en)));

    assert_idle_read_zero_R12: assert property (@(posedge clk) disable iff (fn_domain_rst)
        !acc_rd |=> (acc_rdata == '0));

    assert_reserved_read_zero_R2: assert property (@(posedge clk) disable iff (fn_domain_rst)
        acc_rd |=> ((acc_rdata & ~LIVE_MASK) == '0));

    assert_d3_gates_decode_R8: assert property (@(posedge clk) disable iff (fn_domain_rst)
        (wr_req.ps_we && wr_req.ps_code == 2'b11 && !soft_rst) |=> (!decode_en && irq_mask));

endmodule

// File: tb/test_pm_ctrl_reg.sv
`timescale 1ns/1ps
module test_pm_ctrl_reg;

    logic        clk = 1'b0;
    logic        por_rst, fn_rst;
    logic [7:0]  acc_addr;
    logic        acc_wr, acc_rd;
    logic [3:0]  acc_be;
    logic [31:0] acc_wdata;
    logic [31:0] acc_rdata;
    logic        pme_event;
    logic [1:0]  pwr_state;
    logic        decode_en, irq_mask, wake_req, soft_rst;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pm_ctrl_reg i_pm_ctrl_reg (
        .clk       (clk),
        .por_rst   (por_rst),
        .fn_rst    (fn_rst),
        .acc_addr  (acc_addr),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd),
        .acc_be    (acc_be),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .pme_event (pme_event),
        .pwr_state (pwr_state),
        .decode_en (decode_en),
        .irq_mask  (irq_mask),
        .wake_req  (wake_req),
        .soft_rst  (soft_rst)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [31:0] exp_rd;
        logic [1:0]  exp_ps;
        logic        exp_wake;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{4'd1,  OP_RD, 8'h54, 4'hF, 32'h0000_0000, 32'h0000_0000, 2'b00, 1'b0}, // R1 reset value
        '{4'd2,  OP_WR, 8'h54, 4'hF, 32'hFFFF_FFFF, 32'h0,         2'b11, 1'b0}, // R2 all ones
        '{4'd2,  OP_RD, 8'h54, 4'hF, 32'h0,         32'h0000_0103, 2'b11, 1'b0}, // R2 reserved zero
        '{4'd4,  OP_EV, 8'h54, 4'h0, 32'h0,         32'h0,         2'b11, 1'b1}, // R4 wake request
        '{4'd3,  OP_RD, 8'h54, 4'hF, 32'h0,         32'h0000_8103, 2'b11, 1'b1}, // R3 status set
        '{4'd7,  OP_WR, 8'h54, 4'h1, 32'h0000_0001, 32'h0,         2'b11, 1'b1}, // R7 code 01 dropped
        '{4'd7,  OP_WR, 8'h54, 4'h1, 32'h0000_0002, 32'h0,         2'b11, 1'b1}, // R7 code 10 dropped
        '{4'd4,  OP_WR, 8'h54, 4'h2, 32'h0000_0000, 32'h0,         2'b11, 1'b0}, // R4 enable off
        '{4'd3,  OP_RD, 8'h54, 4'hF, 32'h0,         32'h0000_8003, 2'b11, 1'b0}, // R3 zero keeps status
        '{4'd11, OP_WR, 8'h54, 4'h1, 32'h0000_FF00, 32'h0,         2'b00, 1'b0}, // R11 lane 0 only
        '{4'd11, OP_RD, 8'h54, 4'hF, 32'h0,         32'h0000_8000, 2'b00, 1'b0}, // R11 lane 1 untouched
        '{4'd3,  OP_WR, 8'h54, 4'h2, 32'h0000_8100, 32'h0,         2'b00, 1'b0}, // R3 clear by one
        '{4'd3,  OP_RD, 8'h54, 4'hF, 32'h0,         32'h0000_0100, 2'b00, 1'b0}, // R3 cleared
        '{4'd3,  OP_EV, 8'h54, 4'h0, 32'h0,         32'h0,         2'b00, 1'b1}, // R3 event again
        '{4'd12, OP_WR, 8'h50, 4'hF, 32'h0000_0000, 32'h0,         2'b00, 1'b1}, // R12 miss write
        '{4'd12, OP_RD, 8'h50, 4'hF, 32'h0,         32'h0000_0000, 2'b00, 1'b1}, // R12 miss read
        '{4'd11, OP_WR, 8'h54, 4'hE, 32'h0000_0003, 32'h0,         2'b00, 1'b0}, // R11 lane 0 off
        '{4'd11, OP_RD, 8'h54, 4'hF, 32'h0,         32'h0000_8000, 2'b00, 1'b0}  // R11 readback
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Every task starts at a falling edge and ends at the next one
    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        acc_addr = a; acc_be = be; acc_wdata = d; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0; acc_be = 4'h0; acc_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] q);
        acc_addr = a; acc_rd = 1'b1;
        @(negedge clk);
        acc_rd = 1'b0;
        q = acc_rdata;
    endtask

    task automatic ev;
        pme_event = 1'b1;
        @(negedge clk);
        pme_event = 1'b0;
    endtask

    task automatic pulse_rst(input logic por);
        if (por) por_rst = 1'b1; else fn_rst = 1'b1;
        @(negedge clk);
        por_rst = 1'b0; fn_rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] q;
        por_rst = 1'b1; fn_rst = 1'b1;
        acc_addr = '0; acc_wr = 1'b0; acc_rd = 1'b0; acc_be = '0; acc_wdata = '0;
        pme_event = 1'b0;
        repeat (3) @(negedge clk);
        por_rst = 1'b0; fn_rst = 1'b0;

        // R1 reset state of the outputs
        chk("R1 pwr_state", {30'd0, pwr_state}, 32'd0);
        chk("R1 decode_en", {31'd0, decode_en}, 32'd1);
        chk("R1 irq_mask",  {31'd0, irq_mask},  32'd0);
        chk("R1 soft_rst",  {31'd0, soft_rst},  32'd0);

        for (int i = 0; i < NV; i++) begin
            q = '0;
            case (VT[i].op)
                OP_WR:   wr(VT[i].addr, VT[i].be, VT[i].data);
                OP_RD:   rd(VT[i].addr, q);
                default: ev();
            endcase
            chk($sformatf("R%0d row %0d pwr_state", VT[i].req, i), {30'd0, pwr_state}, {30'd0, VT[i].exp_ps});
            chk($sformatf("R%0d row %0d wake_req", VT[i].req, i), {31'd0, wake_req}, {31'd0, VT[i].exp_wake});
            if (VT[i].op == OP_RD)
                chk($sformatf("R%0d row %0d rdata", VT[i].req, i), q, VT[i].exp_rd);
        end

        // R12 read data only in the cycle after the strobe
        @(negedge clk);
        chk("R12 idle rdata", acc_rdata, 32'd0);

        // R6 power-on reset clears the wake bits
        pulse_rst(1'b1);
        rd(8'h54, q);
        chk("R6 por clears", q, 32'd0);
        chk("R1 wake_req after por", {31'd0, wake_req}, 32'd0);

        // R8 D3hot gating, no pulse on entry (R9)
        wr(8'h54, 4'h1, 32'h3);
        chk("R8 decode_en", {31'd0, decode_en}, 32'd0);
        chk("R8 irq_mask",  {31'd0, irq_mask},  32'd1);
        chk("R9 no pulse entering D3", {31'd0, soft_rst}, 32'd0);
        rd(8'h54, q);
        chk("R8 read in D3", q, 32'h0000_0003);

        // R9 leaving D3hot pulses once
        wr(8'h54, 4'h1, 32'h0);
        chk("R9 pulse high", {31'd0, soft_rst}, 32'd1);
        chk("R9 state D0",   {30'd0, pwr_state}, 32'd0);
        @(negedge clk);
        chk("R9 pulse low",  {31'd0, soft_rst}, 32'd0);
        wr(8'h54, 4'h1, 32'h0);
        chk("R9 no pulse D0 to D0", {31'd0, soft_rst}, 32'd0);

        // R10 soft reset overrides a simultaneous state write and spares wake bits
        ev();
        wr(8'h54, 4'h2, 32'h0000_0100);
        wr(8'h54, 4'h1, 32'h3);
        wr(8'h54, 4'h1, 32'h0);
        wr(8'h54, 4'h1, 32'h3);
        chk("R10 write under pulse overridden", {30'd0, pwr_state}, 32'd0);
        wr(8'h54, 4'h1, 32'h3);
        chk("R10 later write accepted", {30'd0, pwr_state}, 32'd3);
        wr(8'h54, 4'h1, 32'h0);
        rd(8'h54, q);
        chk("R10 wake bits kept", q, 32'h0000_8100);

        // R5 event beats a simultaneous clear
        pme_event = 1'b1;
        wr(8'h54, 4'h2, 32'h0000_8100);
        pme_event = 1'b0;
        rd(8'h54, q);
        chk("R5 event wins", q, 32'h0000_8100);
        wr(8'h54, 4'h2, 32'h0000_8100);
        rd(8'h54, q);
        chk("R3 clear alone", q, 32'h0000_0100);

        // R6 function reset spares the wake bits
        ev();
        wr(8'h54, 4'h1, 32'h3);
        pulse_rst(1'b0);
        chk("R6 fn_rst state D0", {30'd0, pwr_state}, 32'd0);
        chk("R6 fn_rst no pulse", {31'd0, soft_rst}, 32'd0);
        rd(8'h54, q);
        chk("R6 fn_rst keeps wake", q, 32'h0000_8100);
        chk("R4 wake_req held", {31'd0, wake_req}, 32'd1);

        summary();
        $finish;
    end

endmodule